// File: doc/BRIEF.md
# Requeuing DMA Service Request Queue

This block keeps the ordered list of channels that are waiting for a DMA engine to move their buffered data. A channel joins the list when its local buffer reports that it needs attention, for example because a fill threshold was crossed or because a complete message is ready. Channels are served strictly in first-in first-out order, and only the channel at the head is offered to the engine.

The engine takes the head channel with an accept handshake and then runs one bounded transaction for it. Only one transaction is outstanding at a time. When the engine reports completion, it also says whether the channel still holds data. If it does, the channel goes back to the tail of the list. If it does not, the channel leaves the list. Because served channels are sent to the back, every active channel gets a fair round-robin share of the engine.

A channel is never in the list more than once. The list has one slot per channel, so it cannot overflow.

Top module: `svc_req_queue`

## Requirements
- R1: After reset, `head_valid` is 0 and `occupancy` is 0.
- R2: Channels are offered on `head_chan` in the order in which they entered the queue.
- R3: `head_valid` is 1 exactly when `occupancy` is nonzero and no transaction is outstanding. A transaction is outstanding from an accepted head until the next `done_valid`.
- R4: When `head_accept` is high while `head_valid` is high, the head channel leaves the queue, `occupancy` drops by one, and that channel becomes the outstanding transaction.
- R5: When `done_valid` arrives with `done_more`=1, the outstanding channel is appended at the tail of the queue.
- R6: When `done_valid` arrives with `done_more`=0, the outstanding channel is released. A later request for that channel is accepted again.
- R7: A request for a channel that is already queued or outstanding is ignored and leaves `occupancy` unchanged. This holds even in the cycle when that channel completes.
- R8: When a requeue and a new request occur in the same cycle, the requeued channel is written to the tail first and the new channel is placed behind it.
- R9: `occupancy` never exceeds NUM_CH, and all NUM_CH channels can be queued at the same time.
- R10: `head_accept` while `head_valid` is 0 has no effect. `done_valid` with no outstanding transaction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Service request strobe from the buffer manager |
| req_chan | input | $clog2(NUM_CH) | Channel that is requesting service |
| head_valid | output | 1 | Head channel is available to the engine |
| head_chan | output | $clog2(NUM_CH) | Channel at the head of the queue |
| head_accept | input | 1 | Engine takes the head channel |
| done_valid | input | 1 | Engine finished the outstanding transaction |
| done_more | input | 1 | Finished channel still holds data |
| occupancy | output | $clog2(NUM_CH+1) | Number of channels waiting in the queue |

## Verification
The bench checks the cases where a weak design would fail:
- **Requeue collides with a new request.** The same cycle carries a requeue and a new request. A design that wrote the new request first, or dropped one of the two, would show the wrong head order.
- **Duplicate requests.** Repeated requests arrive for a queued channel, for an outstanding channel, and for a channel in its completion cycle. A design without a membership check would let a channel appear twice and inflate the occupancy.
- **Full queue.** All channels are queued at once. This exposes a pointer wrap or count-width error.
- **Stray handshakes.** Stray accepts and completions arrive. A design that acted on them would pop an empty queue or duplicate a channel.

// File: rtl/svc_req_queue_pkg.sv
package svc_req_queue_pkg;
    // Which value a ring write port carries
    typedef enum logic [0:0] {
        SRC_REQUEST = 1'b0,
        SRC_REQUEUE = 1'b1
    } wr_src_e;
endpackage

// File: rtl/srq_ring.sv
// Circular channel store with two ordered write ports and one pop port.
module srq_ring #(
    parameter int DEPTH = 32,
    parameter int DW    = 5,
    localparam int PW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr0_en,
    input  logic [DW-1:0]   wr0_data,
    input  logic            wr1_en,
    input  logic [DW-1:0]   wr1_data,
    input  logic            rd_en,
    output logic [DW-1:0]   head,
    output logic [CNTW-1:0] count
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CNTW-1:0]          cnt;
    } ring_t;

    ring_t r_d, r_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        logic [PW-1:0] wp;
        r_d = r_q;
        wp  = r_q.wr;
        // Port 0 always lands ahead of port 1
        if (wr0_en) begin
            r_d.mem[wp] = wr0_data;
            wp = step(wp);
        end
        if (wr1_en) begin
            r_d.mem[wp] = wr1_data;
            wp = step(wp);
        end
        r_d.wr = wp;
        if (rd_en) r_d.rd = step(r_q.rd);
        r_d.cnt = r_q.cnt + CNTW'(wr0_en) + CNTW'(wr1_en) - CNTW'(rd_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign head  = r_q.mem[r_q.rd];
    assign count = r_q.cnt;
endmodule

// File: rtl/srq_member.sv
// One flag per channel: set while the channel is queued or outstanding.
module srq_member #(
    parameter int NUM_CH = 32,
    localparam int CW    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [CW-1:0]     set_ch,
    input  logic              clr_en,
    input  logic [CW-1:0]     clr_ch,
    output logic [NUM_CH-1:0] flags
);
    logic [NUM_CH-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clr_en) flags_d[clr_ch] = 1'b0;
        if (set_en) flags_d[set_ch] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/svc_req_queue.sv
module svc_req_queue #(
    parameter int NUM_CH = 32,
    localparam int CW    = $clog2(NUM_CH),
    localparam int CNTW  = $clog2(NUM_CH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [CW-1:0]   req_chan,
    output logic            head_valid,
    output logic [CW-1:0]   head_chan,
    input  logic            head_accept,
    input  logic            done_valid,
    input  logic            done_more,
    output logic [CNTW-1:0] occupancy
);
    import svc_req_queue_pkg::*;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] svc;
    } svc_t;

    svc_t s_d, s_q;

    logic [NUM_CH-1:0] member;
    logic              req_ok, pop, fin, requeue;
    logic              wr0_en, wr1_en;
    wr_src_e           wr0_src;
    logic [CW-1:0]     wr0_data;
    logic [CW-1:0]     ring_head;
    logic [CNTW-1:0]   ring_cnt;

    always_comb begin
        req_ok  = req_valid && !member[req_chan];
        pop     = head_accept && head_valid;
        fin     = done_valid && s_q.busy;
        requeue = fin && done_more;

        // A requeue occupies write port 0 so it lands ahead of a new request
        wr0_src  = requeue ? SRC_REQUEUE : SRC_REQUEST;
        wr0_en   = requeue || req_ok;
        wr0_data = (wr0_src == SRC_REQUEUE) ? s_q.svc : req_chan;
        wr1_en   = requeue && req_ok;

        s_d = s_q;
        if (pop) begin
            s_d.busy = 1'b1;
            s_d.svc  = ring_head;
        end else if (fin) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    srq_ring #(.DEPTH(NUM_CH), .DW(CW)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr0_en   (wr0_en),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_data (req_chan),
        .rd_en    (pop),
        .head     (ring_head),
        .count    (ring_cnt)
    );

    srq_member #(.NUM_CH(NUM_CH)) u_member (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (req_ok),
        .set_ch (req_chan),
        .clr_en (fin && !done_more),
        .clr_ch (s_q.svc),
        .flags  (member)
    );

    assign head_valid = (ring_cnt != '0) && !s_q.busy;
    assign head_chan  = ring_head;
    assign occupancy  = ring_cnt;
endmodule

// File: rtl/svc_req_queue_chk.sv
module svc_req_queue_chk #(
    parameter int NUM_CH = 32,
    localparam int CW    = $clog2(NUM_CH),
    localparam int CNTW  = $clog2(NUM_CH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [CW-1:0]   req_chan,
    input logic            head_valid,
    input logic [CW-1:0]   head_chan,
    input logic            head_accept,
    input logic            done_valid,
    input logic            done_more,
    input logic [CNTW-1:0] occupancy
);
    // Outstanding transaction, tracked from port activity only
    logic out_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                        out_q <= 1'b0;
        else if (head_valid && head_accept) out_q <= 1'b1;
        else if (done_valid)                out_q <= 1'b0;
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNTW'(NUM_CH));

    a_r3_head_valid_rule: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid == ((occupancy != '0) && !out_q));

    a_r4_accept_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_accept && !req_valid) |=> (occupancy == $past(occupancy) - CNTW'(1)));

    a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_accept) |=> !head_valid);

    a_r5_requeue_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && done_valid && done_more && !req_valid) |=> (occupancy == $past(occupancy) + CNTW'(1)));

    a_r6_release_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && done_valid && !done_more && !req_valid) |=> $stable(occupancy));

    a_r10_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q && !head_accept && !req_valid) |=> $stable(occupancy));
endmodule

bind svc_req_queue svc_req_queue_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_chan    (req_chan),
    .head_valid  (head_valid),
    .head_chan   (head_chan),
    .head_accept (head_accept),
    .done_valid  (done_valid),
    .done_more   (done_more),
    .occupancy   (occupancy)
);

// File: tb/svc_req_queue_tb.sv
module svc_req_queue_tb;
    localparam int NUM_CH = 32;
    localparam int CW     = $clog2(NUM_CH);
    localparam int CNTW   = $clog2(NUM_CH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [CW-1:0]   req_chan = '0;
    logic            head_valid;
    logic [CW-1:0]   head_chan;
    logic            head_accept = 1'b0;
    logic            done_valid = 1'b0;
    logic            done_more = 1'b0;
    logic [CNTW-1:0] occupancy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    svc_req_queue #(.NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .head_valid(head_valid), .head_chan(head_chan), .head_accept(head_accept),
        .done_valid(done_valid), .done_more(done_more), .occupancy(occupancy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int ch);
        req_valid = 1'b1;
        req_chan  = CW'(ch);
        tick();
        req_valid = 1'b0;
    endtask

    task automatic serve(input int ch, input bit more);
        check("R2 head channel", int'(head_chan), ch);
        check("R3 head valid before accept", int'(head_valid), 1);
        head_accept = 1'b1;
        tick();
        head_accept = 1'b0;
        check("R4 no head while outstanding", int'(head_valid), 0);
        done_valid = 1'b1;
        done_more  = more;
        tick();
        done_valid = 1'b0;
        done_more  = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 head_valid after reset", int'(head_valid), 0);
        check("R1 occupancy after reset", int'(occupancy), 0);
    endtask

    task automatic t_fifo_order();
        push(3); push(7); push(1);
        check("R2 occupancy after three requests", int'(occupancy), 3);
        serve(3, 0);
        check("R4 occupancy after first serve", int'(occupancy), 2);
        serve(7, 0);
        serve(1, 0);
        check("R6 queue empty after releases", int'(occupancy), 0);
        check("R3 no head when empty", int'(head_valid), 0);
    endtask

    task automatic t_duplicate();
        push(5); push(5);
        check("R7 duplicate of queued channel", int'(occupancy), 1);
        head_accept = 1'b1;
        tick();
        head_accept = 1'b0;
        push(5);
        check("R7 duplicate of outstanding channel", int'(occupancy), 0);
        // completion without more data, same-cycle request for that channel
        done_valid = 1'b1; done_more = 1'b0;
        req_valid = 1'b1; req_chan = CW'(5);
        tick();
        done_valid = 1'b0; req_valid = 1'b0;
        check("R7 request in completion cycle ignored", int'(occupancy), 0);
        push(5);
        check("R6 released channel accepted again", int'(occupancy), 1);
        serve(5, 0);
        check("R6 drained", int'(occupancy), 0);
    endtask

    task automatic t_requeue();
        push(2); push(4);
        serve(2, 1);
        check("R5 occupancy after requeue", int'(occupancy), 2);
        serve(4, 0);
        check("R5 requeued channel at head", int'(head_chan), 2);
        serve(2, 0);
        check("R5 drained after requeue", int'(occupancy), 0);
    endtask

    task automatic t_collision();
        push(6);
        head_accept = 1'b1;
        tick();
        head_accept = 1'b0;
        done_valid = 1'b1; done_more = 1'b1;
        req_valid = 1'b1; req_chan = CW'(9);
        tick();
        done_valid = 1'b0; done_more = 1'b0; req_valid = 1'b0;
        check("R8 both written", int'(occupancy), 2);
        serve(6, 0);
        serve(9, 0);
        check("R8 drained", int'(occupancy), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < NUM_CH; i++) push(NUM_CH - 1 - i);
        check("R9 all channels queued", int'(occupancy), NUM_CH);
        push(0);
        check("R9 no overflow on extra request", int'(occupancy), NUM_CH);
        for (int i = 0; i < NUM_CH; i++) serve(NUM_CH - 1 - i, 0);
        check("R9 drained after full", int'(occupancy), 0);
    endtask

    task automatic t_stray();
        head_accept = 1'b1;
        tick();
        head_accept = 1'b0;
        check("R10 accept on empty queue", int'(occupancy), 0);
        push(1);
        done_valid = 1'b1; done_more = 1'b1;
        tick();
        done_valid = 1'b0; done_more = 1'b0;
        check("R10 stray done adds nothing", int'(occupancy), 1);
        check("R10 head still offered", int'(head_valid), 1);
        serve(1, 0);
        check("R10 drained", int'(occupancy), 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fifo_order();
        t_duplicate();
        t_requeue();
        t_collision();
        t_full();
        t_stray();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule